// File: doc/BRIEF.md
# Thermal Throttle Operating-Point Sequencer

This block decides the core's operating point (a frequency ratio and the matching regulator VID code) and protects the die when it runs hot. Under normal conditions it follows a requested ratio, limited to a legal range. Every change of operating point is ordered for safety. When the frequency goes up, the voltage is raised first and allowed to settle. When the frequency goes down, the frequency drops first and the voltage follows. Each voltage step waits for a regulator acknowledge, or for a fixed settle time if no acknowledge arrives.

A thermal event starts when the relative temperature reading (distance below the trip point) reaches a programmable activation offset, which is zero when the offset is not set. An event also starts when an external active-low hot input is pulled low. During an event the block lowers the ratio one step per evaluation interval until it reaches the minimum. If the event still persists after that, it gates the clock with a fixed 1-in-4 duty pattern. The event ends once the reading has moved a hysteresis margin away from the trigger and the hot input is released. Software can also force the same clock gating on its own, at any time, through a separate request.

Top module: `therm_opp_seq`

## Requirements
- R1: After reset, ratio_out equals MIN_RATIO (8), vid_out equals VID_OFS + MIN_RATIO (24), clk_en is 1 and hot_out_n is 1.
- R2: With no thermal event, the ratio settles at req_ratio, clamped into the range MIN_RATIO (8) to MAX_RATIO (40).
- R3: On a move to a higher ratio, vid_out first changes to VID_OFS + target while ratio_out stays unchanged, and only then does ratio_out change to the target.
- R4: On a move to a lower ratio, ratio_out first changes to the target while vid_out stays unchanged, and only then does vid_out change to VID_OFS + target.
- R5: The step that depends on a voltage change waits for vr_ack. With vr_ack high, ratio_out follows a raised vid_out by 1 cycle. With vr_ack low, it follows after SETTLE (8) cycles.
- R6: A thermal event starts when temp_rd is less than or equal to act_ofs (so a reading of 0 with no offset). hot_out_n is driven 0 while that sensor condition holds and is 1 otherwise.
- R7: hot_in_n at 0 starts a thermal event in the same way as the sensor does, but it does not drive hot_out_n low.
- R8: During a thermal event, the ratio falls by exactly one per step, with INTERVAL (16) cycles between successive reductions, until it reaches MIN_RATIO.
- R9: Clock gating starts only when the ratio is at MIN_RATIO and the event persists. It then holds clk_en at 1 for exactly one cycle in every four.
- R10: The event ends only when temp_rd is at least act_ofs + HYST (4) and hot_in_n is 1. Readings inside the hysteresis band keep the gating on. After the exit, clk_en stays 1 and the ratio returns to the request.
- R11: od_mod_en at 1 applies the same 1-in-4 clk_en pattern without any thermal event and leaves the operating point unchanged. Clearing it restores clk_en to a constant 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_rd | input | TW (7) | Relative temperature reading; 0 means at the trip point |
| act_ofs | input | TW (7) | Activation offset; 0 means trip at a reading of 0 |
| hot_in_n | input | 1 | External hot indication, active low |
| req_ratio | input | RW (6) | Requested frequency ratio |
| vr_ack | input | 1 | Regulator acknowledge that the last VID has settled |
| od_mod_en | input | 1 | Software request for on-demand clock gating |
| ratio_out | output | RW (6) | Applied frequency ratio |
| vid_out | output | VW (8) | VID code issued to the regulator |
| clk_en | output | 1 | Clock enable gate for the core clock |
| hot_out_n | output | 1 | Hot drive, low while the sensor condition holds |

## Verification
The in-line assertions check every cycle that the voltage always covers the ratio in use, that a ratio rise never coincides with a VID change, and that a VID fall never coincides with a ratio change. They also check that the ratio stays inside its range and that the clock is gated only at the minimum ratio unless software asked for it. What the assertions cannot show is the exact order of changes across a whole event, the spacing between throttle steps, the settle-time wait versus the acknowledge wait, and the hysteresis band. The bench scenarios show these by comparing every observed operating-point change against a queue of expected steps and by timing the gaps between them.

// File: rtl/therm_opp_seq.sv
module therm_opp_seq #(
  parameter int RW        = 6,
  parameter int VW        = 8,
  parameter int TW        = 7,
  parameter int MIN_RATIO = 8,
  parameter int MAX_RATIO = 40,
  parameter int VID_OFS   = 16,
  parameter int HYST      = 4,
  parameter int INTERVAL  = 16,
  parameter int SETTLE    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_rd,
  input  logic [TW-1:0] act_ofs,
  input  logic          hot_in_n,
  input  logic [RW-1:0] req_ratio,
  input  logic          vr_ack,
  input  logic          od_mod_en,
  output logic [RW-1:0] ratio_out,
  output logic [VW-1:0] vid_out,
  output logic          clk_en,
  output logic          hot_out_n
);

  localparam logic [RW-1:0] MIN_R = RW'(MIN_RATIO);
  localparam logic [RW-1:0] MAX_R = RW'(MAX_RATIO);
  localparam int TMW = $clog2(SETTLE + 1);
  localparam int IVW = $clog2(INTERVAL + 1);
  localparam logic [TMW-1:0] TM_LAST = TMW'(SETTLE - 1);
  localparam logic [IVW-1:0] IV_LAST = IVW'(INTERVAL - 1);

  typedef enum logic [1:0] {S_IDLE, S_DN_V, S_DN_W, S_UP_W} st_t;

  function automatic logic [VW-1:0] vid_of(input logic [RW-1:0] r);
    return VW'(VID_OFS) + VW'(r);
  endfunction

  st_t           st;
  logic [RW-1:0] goal, thr, reqc, tgt;
  logic [TMW-1:0] tmr;
  logic [IVW-1:0] iv;
  logic [1:0]    mph;
  logic          evt, mod_on, hot_q, sens_hot, evt_set, evt_clr, mod_act, v_done;

  assign sens_hot = temp_rd <= act_ofs;
  assign evt_set  = sens_hot | ~hot_in_n;
  assign evt_clr  = ({1'b0, temp_rd} >= ({1'b0, act_ofs} + (TW+1)'(HYST))) & hot_in_n;
  assign reqc     = (req_ratio < MIN_R) ? MIN_R : (req_ratio > MAX_R) ? MAX_R : req_ratio;
  assign tgt      = (evt && thr < reqc) ? thr : reqc;
  assign v_done   = vr_ack | (tmr == TM_LAST);
  assign mod_act  = mod_on | od_mod_en;
  assign clk_en   = ~mod_act | (mph == 2'd0);
  assign hot_out_n = ~hot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_out <= MIN_R;
      vid_out   <= vid_of(MIN_R);
      st        <= S_IDLE;
      goal      <= MIN_R;
      tmr       <= '0;
      evt       <= 1'b0;
      thr       <= MIN_R;
      iv        <= '0;
      mod_on    <= 1'b0;
      mph       <= 2'd0;
      hot_q     <= 1'b0;
    end else begin
      hot_q <= sens_hot;
      evt   <= evt ? ~evt_clr : evt_set;
      mph   <= mod_act ? mph + 2'd1 : 2'd0;

      if (!evt) begin
        thr    <= ratio_out;
        iv     <= '0;
        mod_on <= 1'b0;
      end else if (iv == IV_LAST) begin
        iv <= '0;
        if (thr > MIN_R) thr <= thr - 1'b1;
        else if (ratio_out == MIN_R && st == S_IDLE) mod_on <= 1'b1;
      end else begin
        iv <= iv + 1'b1;
      end

      case (st)
        S_IDLE: begin
          tmr <= '0;
          if (tgt < ratio_out) begin
            ratio_out <= tgt;
            goal      <= tgt;
            st        <= S_DN_V;
          end else if (tgt > ratio_out) begin
            vid_out <= vid_of(tgt);
            goal    <= tgt;
            st      <= S_UP_W;
          end
        end
        S_DN_V: begin
          vid_out <= vid_of(goal);
          tmr     <= '0;
          st      <= S_DN_W;
        end
        S_DN_W: begin
          tmr <= tmr + 1'b1;
          if (v_done) st <= S_IDLE;
        end
        default: begin
          tmr <= tmr + 1'b1;
          if (v_done) begin
            ratio_out <= goal;
            st        <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R3: a ratio rise finds its voltage already in place
  a_r3_vid_before_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_out > $past(ratio_out)) |-> (vid_out == $past(vid_out)) && (vid_out == vid_of(ratio_out)));

  // R3 and R4: voltage always covers the ratio in use
  a_r3_vid_covers: assert property (@(posedge clk) disable iff (!rst_n)
    vid_out >= vid_of(ratio_out));

  // R4: a voltage fall happens only after the ratio has already dropped
  a_r4_freq_before_vid: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_out < $past(vid_out)) |-> (ratio_out == $past(ratio_out)));

  // R2: ratio stays in its legal range
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_out >= MIN_R) && (ratio_out <= MAX_R));

  // R9: thermal gating only at the minimum ratio
  a_r9_gate_at_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !od_mod_en) |-> (ratio_out == MIN_R));

  // R9: a gated window never opens two cycles in a row
  a_r9_one_in_four: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && $past(mod_act) && mod_act && $past(mod_act, 2)) |=> (!clk_en || !mod_act || !$past(mod_act)));

endmodule

// File: tb/therm_opp_seq_test.sv
module therm_opp_seq_test;
  localparam int MINR = 8, MAXR = 40, VOFS = 16, HYST = 4, IVL = 16, STL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] temp_rd = 7'd30, act_ofs = 7'd0;
  logic hot_in_n = 1'b1, vr_ack = 1'b1, od_mod_en = 1'b0;
  logic [5:0] req_ratio = 6'd8;
  logic [5:0] ratio_out;
  logic [7:0] vid_out;
  logic clk_en, hot_out_n;

  therm_opp_seq uut (.clk(clk), .rst_n(rst_n), .temp_rd(temp_rd), .act_ofs(act_ofs),
    .hot_in_n(hot_in_n), .req_ratio(req_ratio), .vr_ack(vr_ack), .od_mod_en(od_mod_en),
    .ratio_out(ratio_out), .vid_out(vid_out), .clk_en(clk_en), .hot_out_n(hot_out_n));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int expq[$];
  string tagq[$];
  int last_r, last_v, t_vid, t_rat, prev_drop, gap_bad, gate_bad;
  bit track_drops = 0, done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vid_of(input int r);
    return VOFS + r;
  endfunction

  task automatic push_move(input int c, input int t);
    if (t < c) begin
      expq.push_back(t * 256 + vid_of(c)); tagq.push_back("R4");
      expq.push_back(t * 256 + vid_of(t)); tagq.push_back("R4");
    end else if (t > c) begin
      expq.push_back(c * 256 + vid_of(t)); tagq.push_back("R3");
      expq.push_back(t * 256 + vid_of(t)); tagq.push_back("R3");
    end
  endtask

  task automatic push_throttle(input int from);
    for (int r = from; r > MINR; r--) push_move(r, r - 1);
  endtask

  // monitor: pop and compare each observed operating-point change
  always @(negedge clk) begin
    if (!rst_n) begin
      last_r = ratio_out; last_v = vid_out;
    end else begin
      if (!clk_en && !od_mod_en && ratio_out != MINR) gate_bad++;
      if (ratio_out != last_r || vid_out != last_v) begin
        if (vid_out != last_v) t_vid = cyc;
        if (ratio_out != last_r) begin
          t_rat = cyc;
          if (track_drops && ratio_out < last_r) begin
            if (prev_drop >= 0 && cyc - prev_drop != IVL) gap_bad++;
            prev_drop = cyc;
          end
        end
        if (expq.size() == 0)
          chk(0, "R2 unexpected change", ratio_out * 256 + vid_out, last_r * 256 + last_v);
        else begin
          int e; string tg;
          e = expq.pop_front(); tg = tagq.pop_front();
          chk(ratio_out * 256 + vid_out == e, tg, ratio_out * 256 + vid_out, e);
        end
        last_r = ratio_out; last_v = vid_out;
      end
    end
  end

  task automatic wait_idle(input int lim);
    int n = 0;
    while (expq.size() != 0 && n < lim) begin @(posedge clk); n++; end
    chk(expq.size() == 0, "R2 queue drained", expq.size(), 0);
    repeat (STL + 4) @(posedge clk);
  endtask

  task automatic count_en(input int n, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (clk_en) ones++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ones;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ratio_out == MINR, "R1 ratio", ratio_out, MINR);
    chk(vid_out == vid_of(MINR), "R1 vid", vid_out, vid_of(MINR));
    chk(clk_en == 1'b1, "R1 clk_en", clk_en, 1);
    chk(hot_out_n == 1'b1, "R1 hot_out_n", hot_out_n, 1);

    // R3 and R5: up with ack
    push_move(8, 20); req_ratio = 6'd20; wait_idle(200);
    chk(ratio_out == 20, "R2 follow", ratio_out, 20);
    chk(t_rat - t_vid == 1, "R5 ack gap", t_rat - t_vid, 1);
    // R5: up without ack waits settle
    vr_ack = 1'b0;
    push_move(20, 24); req_ratio = 6'd24; wait_idle(200);
    chk(t_rat - t_vid == STL, "R5 settle gap", t_rat - t_vid, STL);
    vr_ack = 1'b1;
    // R4: down
    push_move(24, 12); req_ratio = 6'd12; wait_idle(200);
    chk(ratio_out == 12, "R4 down", ratio_out, 12);
    // R2 clamps
    push_move(12, MAXR); req_ratio = 6'd63; wait_idle(200);
    chk(ratio_out == MAXR, "R2 clamp high", ratio_out, MAXR);
    push_move(MAXR, MINR); req_ratio = 6'd2; wait_idle(200);
    chk(ratio_out == MINR, "R2 clamp low", ratio_out, MINR);
    push_move(MINR, 14); req_ratio = 6'd14; wait_idle(200);

    // R6 and R8 and R9: sensor event at reading 0
    gate_bad = 0; gap_bad = 0; prev_drop = -1; track_drops = 1;
    push_throttle(14); temp_rd = 7'd0;
    repeat (3) @(negedge clk);
    chk(hot_out_n == 1'b0, "R6 hot drive", hot_out_n, 0);
    wait_idle(400);
    track_drops = 0;
    chk(ratio_out == MINR, "R8 reached min", ratio_out, MINR);
    chk(gap_bad == 0, "R8 step spacing", gap_bad, 0);
    chk(gate_bad == 0, "R9 no gating above min", gate_bad, 0);
    repeat (2 * IVL) @(posedge clk);
    count_en(16, ones);
    chk(ones == 4, "R9 duty", ones, 4);
    // R10: inside hysteresis band stays gated
    temp_rd = 7'd2;
    repeat (20) @(posedge clk);
    count_en(16, ones);
    chk(ones == 4, "R10 band holds", ones, 4);
    chk(hot_out_n == 1'b1, "R6 hot released", hot_out_n, 1);
    push_move(MINR, 14); temp_rd = 7'd4;
    wait_idle(200);
    count_en(16, ones);
    chk(ones == 16, "R10 gate off", ones, 16);
    chk(ratio_out == 14, "R10 ratio back", ratio_out, 14);

    // R6: activation offset
    act_ofs = 7'd10; temp_rd = 7'd12;
    repeat (40) @(negedge clk);
    chk(ratio_out == 14, "R6 above offset no event", ratio_out, 14);
    chk(hot_out_n == 1'b1, "R6 above offset hot", hot_out_n, 1);
    push_throttle(14); temp_rd = 7'd10;
    repeat (3) @(negedge clk);
    chk(hot_out_n == 1'b0, "R6 offset hot drive", hot_out_n, 0);
    wait_idle(400);
    chk(ratio_out == MINR, "R6 offset throttled", ratio_out, MINR);
    push_move(MINR, 14); temp_rd = 7'd14;
    wait_idle(200);

    // R7: external hot input
    act_ofs = 7'd0; temp_rd = 7'd30;
    push_throttle(14); hot_in_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(hot_out_n == 1'b1, "R7 no drive from pin", hot_out_n, 1);
    wait_idle(400);
    chk(ratio_out == MINR, "R7 throttled", ratio_out, MINR);
    push_move(MINR, 14); hot_in_n = 1'b1;
    wait_idle(200);
    chk(ratio_out == 14, "R7 released", ratio_out, 14);

    // R11: on-demand gating
    od_mod_en = 1'b1;
    repeat (4) @(posedge clk);
    count_en(20, ones);
    chk(ones == 5, "R11 duty", ones, 5);
    chk(ratio_out == 14, "R11 ratio kept", ratio_out, 14);
    od_mod_en = 1'b0;
    repeat (2) @(posedge clk);
    count_en(12, ones);
    chk(ones == 12, "R11 off", ones, 12);
    chk(expq.size() == 0, "R11 no stray change", expq.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule